// File: doc/BRIEF.md
# Indirect-Access I/O Interrupt Router

This block turns edges on a bank of interrupt input pins into interrupt messages for processors. Software reaches all of its state through two registers only: an index register that chooses an internal register, and a 32-bit data window that reads or writes whichever register the index currently names. Behind the window sit a small identification register and a redirection table that gives every pin a two-word entry.

A pin's entry decides whether the pin may interrupt at all (mask), which edge counts (polarity), and what the resulting message carries: an 8-bit vector, a delivery mode, a destination mode and an 8-bit destination. An edge that the entry accepts is recorded as pending for that pin. A single output register then hands pending work out one message at a time over a valid/ready handshake, lowest pin first. An edge that arrives while that pin's previous message is still waiting is kept, not dropped.

Top module: `ioint_router`

## Requirements
- R1: A write to the index register stores the low 8 bits of `sel_wdata` as the index; bits 31:8 are discarded, and `sel_rdata` returns the stored index with bits 31:8 reading zero. A window write updates, and the window read `win_rdata` shows, the register chosen by the current index.
- R2: Index 0x00 is the identification register. Its 4-bit unit ID sits in bits 27:24, is writable, and all other bits read zero.
- R3: Pin p's entry uses index 0x10+2p for its low word and 0x11+2p for its high word. Both words hold all 32 written bits and read back unchanged.
- R4: An index that is neither 0x00 nor in 0x10..0x2F reads zero. A window write to such an index changes no stored state.
- R5: After reset, the ID is zero, every low word is 0x0001_0000 (masked), every high word is zero, and `msg_valid` is low.
- R6: For a pin whose low word has bit 16 = 0, bit 15 = 0 and bit 13 = 0, each rising input edge produces exactly one message, and a falling edge produces none. With `msg_ready` high, `msg_valid` is high in the second rising clock edge after the input change.
- R7: With low-word bit 13 = 1, the pin's falling edge produces a message and its rising edge does not.
- R8: While low-word bit 16 is 1, edges on the pin produce no message. Clearing that bit with a read-modify-write of the low word leaves every other field as it was and re-enables messages.
- R9: A message carries the vector from low bits 7:0, the delivery mode from low bits 10:8, the destination mode from low bit 11 and the destination from high bits 31:24. While `msg_valid` is high and `msg_ready` is low, the message and `msg_valid` hold steady.
- R10: An accepted edge on a pin whose message is still waiting for `msg_ready` is kept as pending and is sent as a further message afterwards.
- R11: When several pins are pending, the lowest-numbered pin is sent first.
- R12: A pin whose low word has bit 15 = 1 (level-triggered) produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_we | input | 1 | Write strobe for the index register |
| sel_wdata | input | 32 | Data for the index register |
| sel_rdata | output | 32 | Current index, zero-extended |
| win_we | input | 1 | Write strobe for the data window |
| win_wdata | input | 32 | Data written through the window |
| win_rdata | output | 32 | Register selected by the index |
| pin_in | input | 16 | Interrupt input pins |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_dest | output | 8 | Message destination |

## Verification
A register write lands on the clock edge that samples the strobe, and the window read is combinational from the stored index, so the bench reads at the falling edge right after the index write. An input change driven at a falling edge becomes pending at the next rising edge and appears on `msg_valid` one rising edge later. The bench checks `msg_valid` low after the first edge and high after the second. Message counts are taken by sampling `valid && ready` at each falling edge from the moment `msg_ready` is raised, so that a handshake in the very next cycle is not missed.

// File: rtl/ioint_pkg.sv
package ioint_pkg;
    localparam int LO_DMODE_BIT = 11;
    localparam int LO_POL_BIT   = 13;
    localparam int LO_TRIG_BIT  = 15;
    localparam int LO_MASK_BIT  = 16;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dlv;
        logic       logical;
        logic [7:0] dest;
    } ioint_msg_t;
endpackage

// File: rtl/ioint_regs.sv
module ioint_regs #(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 8,
    parameter int TBL_BASE = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel_we,
    input  logic [31:0]                  sel_wdata,
    input  logic                         win_we,
    input  logic [31:0]                  win_wdata,
    output logic [31:0]                  sel_rdata,
    output logic [31:0]                  win_rdata,
    output logic [NUM_PINS-1:0][31:0]    lo_o,
    output logic [NUM_PINS-1:0][31:0]    hi_o
);
    localparam int PIN_W = $clog2(NUM_PINS);
    localparam logic [IDX_W-1:0] ID_IDX   = '0;
    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(TBL_BASE);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(TBL_BASE + 2 * NUM_PINS);

    typedef struct packed {
        logic [IDX_W-1:0]          idx;
        logic [3:0]                id;
        logic [NUM_PINS-1:0][31:0] lo;
        logic [NUM_PINS-1:0][31:0] hi;
    } regs_t;

    regs_t r_d, r_q;
    logic             in_tbl;
    logic [IDX_W-1:0] off;
    logic [PIN_W-1:0] pin_sel;
    logic             hi_sel;

    always_comb begin
        in_tbl  = (r_q.idx >= BASE_IDX) && (r_q.idx < END_IDX);
        off     = r_q.idx - BASE_IDX;
        pin_sel = off[PIN_W:1];
        hi_sel  = off[0];

        r_d = r_q;
        if (sel_we) r_d.idx = sel_wdata[IDX_W-1:0];
        if (win_we) begin
            if (r_q.idx == ID_IDX) begin
                r_d.id = win_wdata[27:24];
            end else if (in_tbl) begin
                if (hi_sel) r_d.hi[pin_sel] = win_wdata;
                else        r_d.lo[pin_sel] = win_wdata;
            end
        end

        win_rdata = '0;
        if (r_q.idx == ID_IDX) begin
            win_rdata[27:24] = r_q.id;
        end else if (in_tbl) begin
            win_rdata = hi_sel ? r_q.hi[pin_sel] : r_q.lo[pin_sel];
        end
        sel_rdata = {{(32-IDX_W){1'b0}}, r_q.idx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.idx <= '0;
            r_q.id  <= '0;
            for (int i = 0; i < NUM_PINS; i++) begin
                r_q.lo[i] <= 32'h0001_0000;
                r_q.hi[i] <= '0;
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign lo_o = r_q.lo;
    assign hi_o = r_q.hi;

    // R4
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && !in_tbl) |=> ($stable(r_q.lo) && $stable(r_q.hi)));
endmodule

// File: rtl/ioint_edge.sv
module ioint_edge #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] trig,
    input  logic [NUM_PINS-1:0] grant,
    output logic [NUM_PINS-1:0] pend
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] pend;
    } edge_t;

    edge_t e_d, e_q;
    logic [NUM_PINS-1:0] hit;

    always_comb begin
        // polarity is applied to both samples, so changing it makes no edge
        hit = (pin_in ^ pol) & ~(e_q.prev ^ pol) & ~mask & ~trig;
        e_d.prev = pin_in;
        e_d.pend = (e_q.pend & ~grant) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign pend = e_q.pend;

    // R8
    masked_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((e_q.pend & $past(mask & ~e_q.pend)) == '0));

    // R12
    level_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((e_q.pend & $past(trig & ~e_q.pend)) == '0));
endmodule

// File: rtl/ioint_msgout.sv
module ioint_msgout
    import ioint_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pend,
    input  logic [NUM_PINS-1:0][31:0] lo,
    input  logic [NUM_PINS-1:0][31:0] hi,
    input  logic                      ready,
    output logic [NUM_PINS-1:0]       grant,
    output logic                      valid,
    output ioint_msg_t                msg
);
    localparam int PIN_W = $clog2(NUM_PINS);

    typedef struct packed {
        logic       valid;
        ioint_msg_t msg;
    } out_t;

    out_t o_d, o_q;
    logic             free;
    logic             any;
    logic [PIN_W-1:0] pick;

    always_comb begin
        free = !o_q.valid || ready;
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick = PIN_W'(i);
                any  = 1'b1;
            end
        end

        grant = '0;
        o_d   = o_q;
        if (free) begin
            o_d.valid = any;
            if (any) begin
                grant[pick]   = 1'b1;
                o_d.msg.vector  = lo[pick][7:0];
                o_d.msg.dlv     = lo[pick][10:8];
                o_d.msg.logical = lo[pick][LO_DMODE_BIT];
                o_d.msg.dest    = hi[pick][31:24];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign valid = o_q.valid;
    assign msg   = o_q.msg;

    // R9
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.valid && !ready) |=> (o_q.valid && $stable(o_q.msg)));

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((pend & (grant - NUM_PINS'(1))) == '0));

    // R10
    grant_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~pend) == '0));
endmodule

// File: rtl/ioint_router.sv
module ioint_router
    import ioint_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 8,
    parameter int TBL_BASE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_we,
    input  logic [31:0]         sel_wdata,
    output logic [31:0]         sel_rdata,
    input  logic                win_we,
    input  logic [31:0]         win_wdata,
    output logic [31:0]         win_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_dlv,
    output logic                msg_logical,
    output logic [7:0]          msg_dest
);
    logic [NUM_PINS-1:0][31:0] lo, hi;
    logic [NUM_PINS-1:0]       mask, pol, trig, pend, grant;
    ioint_msg_t                msg;

    ioint_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .TBL_BASE(TBL_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .win_we(win_we), .win_wdata(win_wdata),
        .sel_rdata(sel_rdata), .win_rdata(win_rdata),
        .lo_o(lo), .hi_o(hi)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_fields
        assign mask[p] = lo[p][LO_MASK_BIT];
        assign pol[p]  = lo[p][LO_POL_BIT];
        assign trig[p] = lo[p][LO_TRIG_BIT];
    end

    ioint_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .mask(mask), .pol(pol), .trig(trig),
        .grant(grant), .pend(pend)
    );

    ioint_msgout #(.NUM_PINS(NUM_PINS)) u_out (
        .clk(clk), .rst_n(rst_n), .pend(pend), .lo(lo), .hi(hi),
        .ready(msg_ready), .grant(grant), .valid(msg_valid), .msg(msg)
    );

    assign msg_vector  = msg.vector;
    assign msg_dlv     = msg.dlv;
    assign msg_logical = msg.logical;
    assign msg_dest    = msg.dest;
endmodule

// File: tb/tb_ioint_router.sv
module tb_ioint_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0, win_we = 1'b0, msg_ready = 1'b0;
    logic [31:0] sel_wdata = '0, win_wdata = '0, sel_rdata, win_rdata;
    logic [15:0] pin_in = '0;
    logic        msg_valid, msg_logical;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_dlv;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    ioint_router dut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .sel_rdata(sel_rdata), .win_we(win_we), .win_wdata(win_wdata),
        .win_rdata(win_rdata), .pin_in(pin_in), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dlv(msg_dlv),
        .msg_logical(msg_logical), .msg_dest(msg_dest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all helpers start and end at a falling edge
    task automatic sel_write(input logic [31:0] v);
        sel_we = 1'b1; sel_wdata = v;
        @(negedge clk); sel_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [31:0] v);
        sel_write({24'h0, idx});
        win_we = 1'b1; win_wdata = v;
        @(negedge clk); win_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [31:0] v);
        sel_write({24'h0, idx});
        v = win_rdata;
    endtask

    task automatic prog(input int p, input logic [31:0] lo_w, input logic [31:0] hi_w);
        wr(8'(16 + 2 * p + 1), hi_w);
        wr(8'(16 + 2 * p), lo_w);
    endtask

    task automatic collect(input int n, output int cnt, output logic [7:0] v0, output logic [7:0] v1);
        cnt = 0; v0 = '0; v1 = '0;
        for (int k = 0; k < n; k++) begin
            if (msg_valid && msg_ready) begin
                if (cnt == 0) v0 = msg_vector;
                if (cnt == 1) v1 = msg_vector;
                cnt++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R5 valid", 32'(msg_valid), 32'h0);
        rd(8'h00, v); chk("R5 id", v, 32'h0);
        rd(8'h10, v); chk("R5 lo0", v, 32'h0001_0000);
        rd(8'h2E, v); chk("R5 lo15", v, 32'h0001_0000);
        rd(8'h2F, v); chk("R5 hi15", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        sel_write(32'hFFFF_FF05);
        chk("R1 sel upper", sel_rdata, 32'h0000_0005);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 id", v, 32'h0F00_0000);
        wr(8'h2C, 32'h1234_5678);
        wr(8'h2D, 32'h9ABC_DEF0);
        rd(8'h2C, v); chk("R3 lo14", v, 32'h1234_5678);
        rd(8'h2D, v); chk("R3 hi14", v, 32'h9ABC_DEF0);
        wr(8'h05, 32'hDEAD_BEEF);
        rd(8'h05, v); chk("R4 read 05", v, 32'h0);
        wr(8'h30, 32'hDEAD_BEEF);
        rd(8'h30, v); chk("R4 read 30", v, 32'h0);
        rd(8'h2C, v); chk("R4 table intact", v, 32'h1234_5678);
        rd(8'h2D, v); chk("R4 table intact hi", v, 32'h9ABC_DEF0);
    endtask

    task automatic t_rise;
        int c; logic [7:0] a, b;
        prog(0, 32'h0000_0040, 32'h0);
        msg_ready = 1'b1;
        pin_in[0] = 1'b1;
        @(negedge clk); chk("R6 not yet", 32'(msg_valid), 32'h0);
        @(negedge clk); chk("R6 due", 32'(msg_valid), 32'h1);
        chk("R6 vector", 32'(msg_vector), 32'h40);
        @(negedge clk); chk("R6 single pulse", 32'(msg_valid), 32'h0);
        pin_in[0] = 1'b0;
        collect(6, c, a, b); chk("R6 falling none", 32'(c), 32'h0);
    endtask

    task automatic t_polarity;
        int c; logic [7:0] a, b;
        prog(5, 32'h0000_2045, 32'h0);
        pin_in[5] = 1'b1;
        collect(6, c, a, b); chk("R7 rise none", 32'(c), 32'h0);
        pin_in[5] = 1'b0;
        collect(6, c, a, b); chk("R7 fall one", 32'(c), 32'h1);
        chk("R7 vector", 32'(a), 32'h45);
    endtask

    task automatic t_mask;
        int c; logic [7:0] a, b; logic [31:0] v;
        prog(4, 32'h0001_0B44, 32'h0);
        pin_in[4] = 1'b1;
        collect(6, c, a, b); chk("R8 masked none", 32'(c), 32'h0);
        pin_in[4] = 1'b0;
        rd(8'h18, v);
        wr(8'h18, v & ~32'h0001_0000);
        rd(8'h18, v); chk("R8 rmw fields", v, 32'h0000_0B44);
        pin_in[4] = 1'b1;
        collect(6, c, a, b); chk("R8 unmasked one", 32'(c), 32'h1);
    endtask

    task automatic t_level;
        int c; logic [7:0] a, b;
        prog(6, 32'h0000_8046, 32'h0);
        pin_in[6] = 1'b1;
        collect(6, c, a, b);
        pin_in[6] = 1'b0;
        @(negedge clk);
        pin_in[6] = 1'b1;
        collect(6, c, a, b); chk("R12 level none", 32'(c), 32'h0);
    endtask

    task automatic t_fields;
        int c; logic [7:0] a, b;
        prog(7, 32'h0000_09A5, 32'h3C00_0000);
        msg_ready = 1'b0;
        pin_in[7] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 valid", 32'(msg_valid), 32'h1);
        chk("R9 vector", 32'(msg_vector), 32'hA5);
        chk("R9 dlv", 32'(msg_dlv), 32'h1);
        chk("R9 logical", 32'(msg_logical), 32'h1);
        chk("R9 dest", 32'(msg_dest), 32'h3C);
        @(negedge clk); @(negedge clk);
        chk("R9 held", {msg_valid, msg_dest, msg_vector}, {1'b1, 8'h3C, 8'hA5});
        msg_ready = 1'b1;
        collect(4, c, a, b); chk("R9 one accepted", 32'(c), 32'h1);
    endtask

    task automatic t_pending;
        int c; logic [7:0] a, b;
        prog(2, 32'h0000_0042, 32'h0);
        msg_ready = 1'b0;
        pin_in[2] = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        pin_in[2] = 1'b0;
        @(negedge clk);
        pin_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 still waiting", {msg_valid, msg_vector}, {1'b1, 8'h42});
        msg_ready = 1'b1;
        collect(6, c, a, b);
        chk("R10 count", 32'(c), 32'h2);
        chk("R10 second vector", 32'(b), 32'h42);
    endtask

    task automatic t_priority;
        int c; logic [7:0] a, b;
        prog(1, 32'h0000_0041, 32'h0);
        prog(3, 32'h0000_0043, 32'h0);
        msg_ready = 1'b0;
        pin_in[3] = 1'b1; pin_in[1] = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        msg_ready = 1'b1;
        collect(6, c, a, b);
        chk("R11 count", 32'(c), 32'h2);
        chk("R11 first", 32'(a), 32'h41);
        chk("R11 second", 32'(b), 32'h43);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_rise();
        t_polarity();
        t_mask();
        t_level();
        t_fields();
        t_pending();
        t_priority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule